// File: doc/BRIEF.md
# Descriptor-Driven Frame Receive Engine

This block is the receive half of a frame controller. It takes a byte stream from the line side. Each frame is marked by a valid strobe and a last-byte flag. The engine delivers accepted frames into memory buffers that software names through receive descriptors. Each descriptor is a pair of words in a descriptor RAM that the transmit side also uses. The even word holds status and the odd word holds the buffer byte address. The receive descriptors begin right after the transmit descriptors, at word index twice the transmit-descriptor count.

Frames are checked against the station address unless promiscuous mode is selected. Bytes are packed four to a 32-bit word, with the first byte in the most significant lane, and written to the buffer. At the end of a frame the engine writes back a status word. That word holds the length and the too-short and too-big flags, and has the ready bit cleared. The engine then raises a receive-done interrupt-source pulse. A frame that starts while no descriptor is ready raises a busy pulse instead and is dropped.

The controller has four states:
- IDLE leads to WAIT_BD when receive is enabled.
- WAIT_BD reads the descriptor pair. It goes to RECV on a ready descriptor, or back to IDLE when nothing is ready and receive is disabled.
- RECV leads to WRITE_FIFO at the last byte of an accepted frame.
- WRITE_FIFO flushes the last partial word, writes the descriptor back and returns to IDLE.

Top module: `rxe_engine`

## Requirements
- R1: States run IDLE → WAIT_BD (only while `rx_en` is high) → RECV → WRITE_FIFO → IDLE. In WAIT_BD one descriptor read is issued (`bd_rd_en` for one cycle) and its result is evaluated on the following cycle.
- R2: A descriptor is ready when status bit 15 is set. In the written-back status, error bits 6:0 are cleared except those set by R9, and bits 14:7 are kept as read.
- R3: In WAIT_BD with no ready descriptor and `rx_en` low, the engine goes to IDLE. Frames arriving then cause no descriptor write, no memory write and no busy pulse.
- R4: A frame that starts in WAIT_BD while `rx_en` is high and no descriptor is ready pulses `int_busy` once. `irq` pulses with it only when `mask_busy` is set. The frame is dropped.
- R5: Unless `promisc` is set, received byte k (k = 0..5) must equal `station_addr[47-8k -: 8]`. On any mismatch the whole frame is dropped, with no write-back, and the descriptor stays ready.
- R6: Data words carry received byte 4w+j in bits [31-8j -: 8] and are written to the buffer address plus 4w.
- R7: The final partial word has its unused low-order lanes set to zero.
- R8: At frame end the status word gets the length in bits 31:16 and bit 15 cleared, and `int_rxb` pulses in the same cycle as `bd_wr_en`.
- R9: Bit 1 (too short) is set when length + 4 < `min_frame`. Bit 2 (too big) is set when length > `max_frame`.
- R10: The first receive index after reset is 2 × `tx_desc_count`. After a write-back the index becomes 2 × `tx_desc_count` if status bit 13 (wrap) is set or the index is the last pair (`BD_WORDS`-2). Otherwise it becomes index + 2.
- R11: With the write-back, `irq` pulses only when `mask_rxb` is set and status bit 14 of the descriptor is set.
- R12: A frame shorter than 14 bytes is discarded without write-back, and the same descriptor takes the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| rx_en | input | 1 | Receive enable |
| promisc | input | 1 | Accept every destination address |
| station_addr | input | 48 | Station address, byte 0 in bits 47:40 |
| min_frame | input | 16 | Minimum frame length setting |
| max_frame | input | 16 | Maximum frame length setting |
| tx_desc_count | input | 6 | Number of transmit descriptors |
| mask_busy | input | 1 | Enables `irq` on busy |
| mask_rxb | input | 1 | Enables `irq` on receive done |
| in_valid | input | 1 | Byte strobe |
| in_data | input | 8 | Received byte |
| in_last | input | 1 | Last byte of frame |
| bd_rd_en | output | 1 | Descriptor pair read request |
| bd_rd_idx | output | 7 | Even word index of the pair |
| bd_rd_stat | input | 32 | Status word, one cycle after request |
| bd_rd_buf | input | 32 | Buffer address word, one cycle after request |
| bd_wr_en | output | 1 | Status write-back strobe |
| bd_wr_idx | output | 7 | Word index of write-back |
| bd_wr_data | output | 32 | Written-back status |
| mem_wr_en | output | 1 | Buffer word write strobe |
| mem_wr_addr | output | 32 | Buffer byte address |
| mem_wr_data | output | 32 | Packed data word |
| int_busy | output | 1 | Busy interrupt-source pulse |
| int_rxb | output | 1 | Receive-done interrupt-source pulse |
| irq | output | 1 | Masked interrupt pulse |

## Verification
The in-line assertions check these properties on every cycle:
- busy pulses occur only in WAIT_BD with receive enabled;
- every done pulse coincides with a write-back that clears the ready bit;
- `irq` never fires without a pulse that its mask allows;
- the ring index stays even;
- the flushed last word is zero beyond the frame length;
- a descriptor read is never issued on two cycles in a row.

Only the directed scenarios can show the behaviours that need the descriptor contents and the memory image. These are:
- the exact written-back status word;
- the byte order of the packed data;
- filter drops and promiscuous acceptance;
- short-frame discard that leaves the descriptor for the next frame;
- wrap to twice the transmit count and the last-pair rule;
- frames arriving while receive is disabled being ignored.

// File: rtl/rxe_pkg.sv
package rxe_pkg;
    localparam int LEN_W      = 16;
    localparam int HDR_BYTES  = 14;
    localparam int ST_READY   = 15;
    localparam int ST_IRQ     = 14;
    localparam int ST_WRAP    = 13;
    localparam int ST_SHORT   = 1;
    localparam int ST_BIG     = 2;
    localparam logic [15:0] ST_KEEP = 16'h7F80;

    typedef enum logic [1:0] {
        S_IDLE       = 2'd0,
        S_WAIT_BD    = 2'd1,
        S_RECV       = 2'd2,
        S_WRITE_FIFO = 2'd3
    } rxe_state_t;
endpackage

// File: rtl/rxe_addr_check.sv
module rxe_addr_check
    import rxe_pkg::*;
(
    input  logic [47:0]      station,
    input  logic [LEN_W-1:0] pos,
    input  logic [7:0]       din,
    output logic             miss
);
    logic [7:0] want;
    logic       in_hdr;

    always_comb begin
        want   = 8'h00;
        in_hdr = 1'b0;
        for (int i = 0; i < 6; i++) begin
            if (pos == LEN_W'(i)) begin
                want   = station[8*(5-i) +: 8];
                in_hdr = 1'b1;
            end
        end
        miss = in_hdr && (din != want);
    end
endmodule

// File: rtl/rxe_word_packer.sv
module rxe_word_packer (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        take,
    input  logic        first,
    input  logic [1:0]  lane,
    input  logic [7:0]  din,
    output logic [31:0] word_now,
    output logic [31:0] held
);
    logic [31:0] acc;
    logic [4:0]  sh;

    always_comb begin
        sh       = {3'd3 - {1'b0, lane}, 3'b000};
        word_now = (first ? 32'h0 : acc) | (32'(din) << sh);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            acc <= 32'h0;
        else if (take)
            acc <= (lane == 2'd3) ? 32'h0 : word_now;
    end

    assign held = acc;
endmodule

// File: rtl/rxe_ring_step.sv
module rxe_ring_step #(
    parameter int BD_WORDS = 128,
    localparam int IDX_W   = $clog2(BD_WORDS)
) (
    input  logic [IDX_W-1:0] cur,
    input  logic             wrap,
    input  logic [IDX_W-2:0] tx_count,
    output logic [IDX_W-1:0] base,
    output logic [IDX_W-1:0] nxt
);
    localparam logic [IDX_W-1:0] LAST_PAIR = IDX_W'(BD_WORDS - 2);

    always_comb begin
        base = {tx_count, 1'b0};
        if (wrap || cur >= LAST_PAIR)
            nxt = base;
        else
            nxt = cur + IDX_W'(2);
    end
endmodule

// File: rtl/rxe_engine.sv
module rxe_engine
    import rxe_pkg::*;
#(
    parameter int BD_WORDS = 128,
    parameter int ADDR_W   = 32,
    localparam int IDX_W   = $clog2(BD_WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_en,
    input  logic              promisc,
    input  logic [47:0]       station_addr,
    input  logic [LEN_W-1:0]  min_frame,
    input  logic [LEN_W-1:0]  max_frame,
    input  logic [IDX_W-2:0]  tx_desc_count,
    input  logic              mask_busy,
    input  logic              mask_rxb,
    input  logic              in_valid,
    input  logic [7:0]        in_data,
    input  logic              in_last,
    output logic              bd_rd_en,
    output logic [IDX_W-1:0]  bd_rd_idx,
    input  logic [31:0]       bd_rd_stat,
    input  logic [ADDR_W-1:0] bd_rd_buf,
    output logic              bd_wr_en,
    output logic [IDX_W-1:0]  bd_wr_idx,
    output logic [31:0]       bd_wr_data,
    output logic              mem_wr_en,
    output logic [ADDR_W-1:0] mem_wr_addr,
    output logic [31:0]       mem_wr_data,
    output logic              int_busy,
    output logic              int_rxb,
    output logic              irq
);
    rxe_state_t state, nstate;

    logic [IDX_W-1:0]  idx;
    logic              started;
    logic              rd_pend;
    logic              bd_empty;
    logic [15:0]       bd_stat;
    logic [ADDR_W-1:0] bd_buf;
    logic              mid_frame;
    logic              taking;
    logic [LEN_W-1:0]  cnt;
    logic [LEN_W-1:0]  fin_len;
    logic              fin_part;

    logic              sof;
    logic              take;
    logic              miss_raw;
    logic              miss;
    logic [LEN_W-1:0]  bidx;
    logic [LEN_W-1:0]  blen;
    logic              long_enough;
    logic              frame_done;
    logic [31:0]       word_now;
    logic [31:0]       held;
    logic [IDX_W-1:0]  ring_base;
    logic [IDX_W-1:0]  ring_next;
    logic              desc_ready;
    logic              no_bd;
    logic [LEN_W-1:0]  last_pos;
    logic              f_short;
    logic              f_big;

    // ---------------- input framing ----------------
    assign sof         = in_valid && !mid_frame;
    assign bidx        = sof ? '0 : cnt;
    assign blen        = bidx + LEN_W'(1);
    assign take        = (state == S_RECV) && in_valid && (sof || taking);
    assign miss        = miss_raw && !promisc;
    assign long_enough = blen >= LEN_W'(HDR_BYTES);
    assign frame_done  = take && !miss && in_last && long_enough;
    assign desc_ready  = bd_rd_stat[ST_READY];
    assign no_bd       = bd_empty || (rd_pend && !desc_ready);
    assign last_pos    = fin_len - LEN_W'(1);
    assign f_short     = ({1'b0, fin_len} + 17'd4) < {1'b0, min_frame};
    assign f_big       = fin_len > max_frame;

    rxe_addr_check u_filt (
        .station (station_addr),
        .pos     (bidx),
        .din     (in_data),
        .miss    (miss_raw)
    );

    rxe_word_packer u_pack (
        .clk      (clk),
        .rst_n    (rst_n),
        .take     (take),
        .first    (sof),
        .lane     (bidx[1:0]),
        .din      (in_data),
        .word_now (word_now),
        .held     (held)
    );

    rxe_ring_step #(.BD_WORDS(BD_WORDS)) u_ring (
        .cur      (idx),
        .wrap     (bd_stat[ST_WRAP]),
        .tx_count (tx_desc_count),
        .base     (ring_base),
        .nxt      (ring_next)
    );

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= S_IDLE;
        else
            state <= nstate;
    end

    // ---------------- next state and outputs ----------------
    always_comb begin
        nstate      = state;
        bd_rd_en    = 1'b0;
        bd_rd_idx   = idx;
        bd_wr_en    = 1'b0;
        bd_wr_idx   = idx;
        bd_wr_data  = 32'h0;
        mem_wr_en   = 1'b0;
        mem_wr_addr = bd_buf + ADDR_W'({bidx[LEN_W-1:2], 2'b00});
        mem_wr_data = word_now;
        int_busy    = 1'b0;
        int_rxb     = 1'b0;
        unique case (state)
            S_IDLE: begin
                if (rx_en)
                    nstate = S_WAIT_BD;
            end
            S_WAIT_BD: begin
                bd_rd_en = !rd_pend;
                int_busy = rx_en && sof && no_bd;
                if (rd_pend) begin
                    if (desc_ready)
                        nstate = S_RECV;
                    else if (!rx_en)
                        nstate = S_IDLE;
                end
            end
            S_RECV: begin
                mem_wr_en = take && !miss && (bidx[1:0] == 2'd3);
                if (frame_done)
                    nstate = S_WRITE_FIFO;
            end
            S_WRITE_FIFO: begin
                mem_wr_en   = fin_part;
                mem_wr_addr = bd_buf + ADDR_W'({last_pos[LEN_W-1:2], 2'b00});
                mem_wr_data = held;
                bd_wr_en    = 1'b1;
                bd_wr_data  = {fin_len, (bd_stat & ST_KEEP)};
                bd_wr_data[ST_SHORT] = f_short;
                bd_wr_data[ST_BIG]   = f_big;
                int_rxb     = 1'b1;
                nstate      = S_IDLE;
            end
            default: nstate = S_IDLE;
        endcase
        irq = (int_busy && mask_busy) ||
              (int_rxb && mask_rxb && bd_stat[ST_IRQ]);
    end

    // ---------------- datapath registers ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx       <= '0;
            started   <= 1'b0;
            rd_pend   <= 1'b0;
            bd_empty  <= 1'b0;
            bd_stat   <= 16'h0;
            bd_buf    <= '0;
            mid_frame <= 1'b0;
            taking    <= 1'b0;
            cnt       <= '0;
            fin_len   <= '0;
            fin_part  <= 1'b0;
        end else begin
            if (in_valid)
                mid_frame <= !in_last;
            rd_pend <= bd_rd_en;

            if (state == S_IDLE && !started) begin
                idx     <= ring_base;
                started <= 1'b1;
            end

            if (state == S_WAIT_BD && rd_pend) begin
                bd_stat  <= bd_rd_stat[15:0];
                bd_buf   <= bd_rd_buf;
                bd_empty <= !desc_ready;
                taking   <= 1'b0;
                cnt      <= '0;
            end else if (state != S_WAIT_BD) begin
                bd_empty <= 1'b0;
            end

            if (take) begin
                if (miss || in_last) begin
                    taking <= 1'b0;
                    cnt    <= '0;
                end else begin
                    taking <= 1'b1;
                    cnt    <= blen;
                end
            end
            if (frame_done) begin
                fin_len  <= blen;
                fin_part <= bidx[1:0] != 2'd3;
            end

            if (state == S_WRITE_FIFO)
                idx <= ring_next;
        end
    end

    // ---------------- assertions ----------------
    AST_ONE_READ: assert property (@(posedge clk) disable iff (!rst_n)
        bd_rd_en |=> !bd_rd_en); // R1

    AST_NO_LOST_DESC: assert property (@(posedge clk) disable iff (!rst_n)
        int_busy |-> (state == S_WAIT_BD) && rx_en && !bd_wr_en); // R4

    AST_DONE_WB: assert property (@(posedge clk) disable iff (!rst_n)
        int_rxb |-> bd_wr_en && !bd_wr_data[ST_READY]); // R8

    AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (int_busy && mask_busy) || (int_rxb && mask_rxb)); // R11

    AST_IDX_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
        (state != S_IDLE) |-> !idx[0]); // R10

    AST_PAD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_WRITE_FIFO && mem_wr_en) |->
            ((fin_len[1:0] == 2'd1) ? (mem_wr_data[23:0] == 24'h0) :
             (fin_len[1:0] == 2'd2) ? (mem_wr_data[15:0] == 16'h0) :
                                      (mem_wr_data[7:0] == 8'h0))); // R7
endmodule

// File: tb/sim_rxe_engine.sv
module sim_rxe_engine;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx_en = 1'b0;
    logic        promisc = 1'b0;
    logic [47:0] station_addr = 48'h0A1B2C3D4E5F;
    logic [15:0] min_frame = 16'd20;
    logic [15:0] max_frame = 16'd1536;
    logic [5:0]  tx_desc_count = 6'd4;
    logic        mask_busy = 1'b0;
    logic        mask_rxb = 1'b1;
    logic        in_valid = 1'b0;
    logic [7:0]  in_data = 8'h0;
    logic        in_last = 1'b0;
    logic        bd_rd_en;
    logic [6:0]  bd_rd_idx;
    logic [31:0] bd_rd_stat;
    logic [31:0] bd_rd_buf;
    logic        bd_wr_en;
    logic [6:0]  bd_wr_idx;
    logic [31:0] bd_wr_data;
    logic        mem_wr_en;
    logic [31:0] mem_wr_addr;
    logic [31:0] mem_wr_data;
    logic        int_busy;
    logic        int_rxb;
    logic        irq;

    int n_chk = 0;
    int n_bad = 0;
    int c_busy = 0;
    int c_rxb = 0;
    int c_irq = 0;
    int c_mem = 0;
    int c_wb = 0;

    logic [31:0] bd_ram [0:127];
    logic [31:0] mem [0:255];
    logic [7:0]  fb [0:63];

    always #4 clk = ~clk;

    rxe_engine u0 (.*);

    always @(posedge clk) begin
        if (bd_rd_en) begin
            bd_rd_stat <= bd_ram[bd_rd_idx];
            bd_rd_buf  <= bd_ram[bd_rd_idx + 7'd1];
        end
        if (bd_wr_en) begin
            bd_ram[bd_wr_idx] <= bd_wr_data;
            c_wb <= c_wb + 1;
        end
        if (mem_wr_en) begin
            mem[mem_wr_addr[9:2]] <= mem_wr_data;
            c_mem <= c_mem + 1;
        end
        if (int_busy) c_busy <= c_busy + 1;
        if (int_rxb)  c_rxb <= c_rxb + 1;
        if (irq)      c_irq <= c_irq + 1;
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic build(input int len, input logic [7:0] seed);
        for (int i = 0; i < 64; i++) fb[i] = seed + 8'(i);
        for (int k = 0; k < 6; k++) fb[k] = station_addr[47-8*k -: 8];
        if (len < 0) fb[0] = 8'h00;
    endtask

    task automatic send(input int len);
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_data  = fb[i];
            in_last  = (i == len - 1);
        end
        @(negedge clk);
        in_valid = 1'b0;
        in_last  = 1'b0;
        repeat (10) @(negedge clk);
    endtask

    task automatic set_bd(input int i, input logic [31:0] st, input logic [31:0] buff);
        bd_ram[i]     = st;
        bd_ram[i + 1] = buff;
        repeat (8) @(negedge clk);
    endtask

    task automatic clear_buf(input int w0);
        for (int w = 0; w < 16; w++) mem[w0 + w] = 32'hFFFF_FFFF;
    endtask

    function automatic logic [31:0] exp_word(input int w, input int len);
        logic [31:0] r = 32'h0;
        for (int j = 0; j < 4; j++)
            if (4*w + j < len) r[31-8*j -: 8] = fb[4*w + j];
        return r;
    endfunction

    function automatic logic [31:0] exp_st(input logic [31:0] orig, input int len, input bit sh, input bit bg);
        return (orig & 32'h0000_7F80) | (32'(len) << 16) | {29'h0, bg, sh, 1'b0};
    endfunction

    task automatic t_reset;
        chk(!mem_wr_en && !bd_wr_en && !irq && !int_busy && !int_rxb && !bd_rd_en,
            "R1 reset outputs", {26'h0, mem_wr_en, bd_wr_en, irq, int_busy, int_rxb, bd_rd_en}, 32'h0);
    endtask

    task automatic t_basic;
        int rxb0 = c_rxb, irq0 = c_irq;
        clear_buf(64);
        set_bd(8, 32'h0000_C47F, 32'h100);
        build(23, 8'h40);
        send(23);
        chk(bd_ram[8] == exp_st(32'h0000_C47F, 23, 0, 0), "R2 R8 first index 8 writeback", bd_ram[8], exp_st(32'h0000_C47F, 23, 0, 0));
        for (int w = 0; w < 5; w++)
            chk(mem[64 + w] == exp_word(w, 23), "R6 word order", mem[64 + w], exp_word(w, 23));
        chk(mem[69] == exp_word(5, 23), "R7 pad partial", mem[69], exp_word(5, 23));
        chk(c_rxb == rxb0 + 1, "R8 rxb pulse", c_rxb, rxb0 + 1);
        chk(c_irq == irq0 + 1, "R11 irq with mask and desc bit", c_irq, irq0 + 1);
    endtask

    task automatic t_filter;
        int rxb0 = c_rxb, irq0 = c_irq;
        clear_buf(128);
        set_bd(10, 32'h0000_8000, 32'h200);
        build(20, 8'h80);
        fb[5] = fb[5] ^ 8'h01;
        send(20);
        chk(bd_ram[10] == 32'h0000_8000, "R5 mismatch keeps desc", bd_ram[10], 32'h0000_8000);
        chk(c_rxb == rxb0, "R5 mismatch no rxb", c_rxb, rxb0);
        promisc = 1'b1;
        send(20);
        promisc = 1'b0;
        chk(bd_ram[10] == exp_st(32'h8000, 20, 0, 0), "R5 promisc accepts", bd_ram[10], exp_st(32'h8000, 20, 0, 0));
        chk(mem[128] == exp_word(0, 20), "R5 R6 promisc data", mem[128], exp_word(0, 20));
        chk(c_irq == irq0, "R11 no irq without desc bit", c_irq, irq0);
    endtask

    task automatic t_short;
        int rxb0 = c_rxb;
        set_bd(12, 32'h0000_A000, 32'h300);
        build(15, 8'hC0);
        send(10);
        chk(bd_ram[12] == 32'h0000_A000, "R12 runt leaves desc", bd_ram[12], 32'h0000_A000);
        chk(c_rxb == rxb0, "R12 runt no rxb", c_rxb, rxb0);
        send(15);
        chk(bd_ram[12] == exp_st(32'hA000, 15, 1, 0), "R9 R12 too short", bd_ram[12], exp_st(32'hA000, 15, 1, 0));
    endtask

    task automatic t_big;
        max_frame = 16'd30;
        clear_buf(64);
        set_bd(8, 32'h0000_8000, 32'h100);
        build(40, 8'h10);
        send(40);
        max_frame = 16'd1536;
        chk(bd_ram[8] == exp_st(32'h8000, 40, 0, 1), "R10 wrap to 2*count, R9 too big", bd_ram[8], exp_st(32'h8000, 40, 0, 1));
    endtask

    task automatic t_busy;
        int b0 = c_busy, i0 = c_irq, m0 = c_mem, w0 = c_wb;
        build(20, 8'h20);
        send(20);
        chk(c_busy == b0 + 1, "R4 busy pulse", c_busy, b0 + 1);
        chk(c_irq == i0, "R4 busy masked off", c_irq, i0);
        mask_busy = 1'b1;
        send(20);
        mask_busy = 1'b0;
        chk(c_busy == b0 + 2, "R4 busy pulse again", c_busy, b0 + 2);
        chk(c_irq == i0 + 1, "R4 busy irq when masked on", c_irq, i0 + 1);
        chk(c_mem == m0 && c_wb == w0, "R4 frame dropped", c_mem + c_wb, m0 + w0);
    endtask

    task automatic t_disable;
        int b0 = c_busy, w0 = c_wb;
        rx_en = 1'b0;
        repeat (6) @(negedge clk);
        set_bd(10, 32'h0000_A000, 32'h200);
        build(20, 8'h30);
        send(20);
        chk(bd_ram[10] == 32'h0000_A000 && c_wb == w0, "R3 disabled ignores frame", bd_ram[10], 32'h0000_A000);
        chk(c_busy == b0, "R3 no busy when disabled", c_busy, b0);
        tx_desc_count = 6'd63;
        rx_en = 1'b1;
        repeat (8) @(negedge clk);
        send(20);
        chk(bd_ram[10] == exp_st(32'hA000, 20, 0, 0), "R1 R3 resumes at kept index", bd_ram[10], exp_st(32'hA000, 20, 0, 0));
    endtask

    task automatic t_lastpair;
        set_bd(126, 32'h0000_8000, 32'h300);
        build(20, 8'h50);
        send(20);
        chk(bd_ram[126] == exp_st(32'h8000, 20, 0, 0), "R10 wrap to base 126", bd_ram[126], exp_st(32'h8000, 20, 0, 0));
        set_bd(126, 32'h0000_8000, 32'h300);
        send(21);
        chk(bd_ram[126] == exp_st(32'h8000, 21, 0, 0), "R10 last pair returns to base", bd_ram[126], exp_st(32'h8000, 21, 0, 0));
    endtask

    initial begin
        bd_rd_stat = 32'h0;
        bd_rd_buf  = 32'h0;
        for (int i = 0; i < 128; i++) bd_ram[i] = 32'h0;
        for (int i = 0; i < 256; i++) mem[i] = 32'h0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        rx_en = 1'b1;
        repeat (4) @(negedge clk);
        t_basic();
        t_filter();
        t_short();
        t_big();
        t_busy();
        t_disable();
        t_lastpair();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=%h expected=%h", 32'h1, 32'h0);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule